// File: doc/BRIEF.md
# Boundary-Scan Test Data Register Path

This block holds the data-register side of a serial test port for a small pin set. The pins are plain inputs, a group of tri-state outputs that share one enable, and bidirectional pins that each have their own direction. It holds a one-bit pass-through stage and a chain of boundary cells. Each boundary cell has a master stage and a slave stage. Each bidirectional pin has a control cell that sets its direction, and the tri-state group has one control cell that can float the whole group. A test-port state decoder outside this block supplies capture, shift and update strobes and a 2-bit instruction code. The block then routes the serial input through the selected register, retimes the serial output and, in external-test mode, drives the pins and the core-side inputs from the slave stages.

Under pass-through and sample modes the cells are transparent: the core drives the pins and the pins drive the core. Under external-test mode the pins and core inputs follow the slave stages instead. Capture and shift act on the rising test clock edge. Update and serial-output retiming act on the falling edge. All state clears through a synchronous active-high reset.

Top module: `bscan_dr_path`

## Requirements
- R1: After reset every master, slave, pass-through and output register is 0, and tdo_oe is 0. Under instruction code 2 the pins then show core_in=0, pin_bd_do=0, pin_bd_oe=0, pin_tri_do=0 and pin_tri_oe=1.
- R2: Under any instruction code other than 2, core_in equals in_pin, pin_tri_do/pin_tri_oe equal core_tri_do/core_tri_oe, pin_bd_do/pin_bd_oe equal core_bd_do/core_bd_oe, and core_bd_di equals pin_bd_di. These hold whatever the slave stages contain.
- R3: Under instruction code 0 the chain is a single stage. Capture loads 0 into it, and each shift clock delays tdi by one bit toward tdo.
- R4: Codes 1 and 2 select the boundary chain of length L=2*N_BD+N_TRI+1+N_IN. Capture loads all masters in parallel, and shifting then presents them on tdo nearest-to-tdo first. That order is: in_pin[N_IN-1] down to in_pin[0]; then the inverse of core_tri_oe; then core_tri_do[N_TRI-1] down to core_tri_do[0]; then, for k from N_BD-1 down to 0, core_bd_oe[k] followed by pin_bd_di[k].
- R5: Data shifted in on tdi comes out on tdo unchanged, after exactly L shift clocks of the boundary chain.
- R6: The slave stages copy the masters only on a falling tck edge where update_dr is 1 and the code is 1 or 2. The new value is visible on the pins before the next rising edge.
- R7: Under code 2 a tri-state control slave of 1 sets pin_tri_oe to 0 (high impedance), and a 0 sets it to 1. pin_tri_do follows the tri-state data slaves.
- R8: Under code 2 a bidirectional control slave of 1 sets that pin_bd_oe bit to 1 (output). pin_bd_do and core_bd_di both follow the bidirectional data slave, and core_in follows the input slaves.
- R9: tdo and tdo_oe change only on a falling tck edge. tdo_oe is 1 exactly after a falling edge that saw shift_dr=1. tdo then holds the least significant bit of the selected register.
- R10: Under code 0, capture, shift and update strobes leave every boundary master and slave unchanged.
- R11: Code 3 behaves exactly as code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial test data in |
| capture_dr | input | 1 | Capture strobe from the state decoder |
| shift_dr | input | 1 | Shift strobe from the state decoder |
| update_dr | input | 1 | Update strobe from the state decoder |
| instr | input | 2 | 0 pass-through, 1 sample, 2 external test, 3 pass-through |
| tdo | output | 1 | Serial test data out, falling-edge retimed |
| tdo_oe | output | 1 | Drive enable for tdo |
| in_pin | input | N_IN | Input pins |
| core_in | output | N_IN | Input pin values toward the core |
| core_tri_do | input | N_TRI | Core data for tri-state outputs |
| core_tri_oe | input | 1 | Core enable for tri-state group |
| pin_tri_do | output | N_TRI | Tri-state output pin data |
| pin_tri_oe | output | 1 | Tri-state group pin enable |
| core_bd_do | input | N_BD | Core data for bidirectional pins |
| core_bd_oe | input | N_BD | Core direction for bidirectional pins (1 = output) |
| pin_bd_do | output | N_BD | Bidirectional pin output data |
| pin_bd_oe | output | N_BD | Bidirectional pin output enable |
| pin_bd_di | input | N_BD | Bidirectional pin sampled value |
| core_bd_di | output | N_BD | Bidirectional pin value toward the core |

## Verification
The properties assume that the strobes and the instruction code change only shortly after a rising tck edge, in the way a test-port state decoder changes them. This keeps each value steady through the falling edge that follows and the rising edge after it. The tdi one-bit-delay property assumes the same of tdi. The stimulus meets these assumptions because every input is driven a quarter period after the rising edge and held for a full period. It also keeps shift_dr low during reset and changes the instruction only while no strobe is active.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        INS_BYPASS = 2'd0,
        INS_SAMPLE = 2'd1,
        INS_EXTEST = 2'd2,
        INS_SPARE  = 2'd3
    } dr_instr_e;

    typedef struct packed {
        logic cap;
        logic shf;
        logic upd;
    } dr_strobe_t;

    function automatic int chain_len(int n_in, int n_tri, int n_bd);
        return 2 * n_bd + n_tri + 1 + n_in;
    endfunction

    // bidirectional data cell k sits nearest tdi
    function automatic int bd_data_pos(int len, int k);
        return len - 1 - 2 * k;
    endfunction

    function automatic int bd_ctl_pos(int len, int k);
        return len - 2 - 2 * k;
    endfunction

    function automatic int tri_data_pos(int len, int n_bd, int j);
        return len - 1 - 2 * n_bd - j;
    endfunction

    function automatic int tri_ctl_pos(int len, int n_bd, int n_tri);
        return len - 1 - 2 * n_bd - n_tri;
    endfunction

    function automatic int in_pos(int n_in, int m);
        return n_in - 1 - m;
    endfunction

    function automatic logic picks_boundary(dr_instr_e code);
        return (code == INS_SAMPLE) || (code == INS_EXTEST);
    endfunction

endpackage

// File: rtl/bscan_bypass.sv
module bscan_bypass
    import bscan_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  dr_strobe_t stb,
    input  logic       tdi,
    output logic       q
);
    always_ff @(posedge tck) begin
        if (rst)          q <= 1'b0;
        else if (stb.cap) q <= 1'b0;
        else if (stb.shf) q <= tdi;
    end
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int LEN = 12
) (
    input  logic             tck,
    input  logic             rst,
    input  dr_strobe_t       stb,
    input  logic             tdi,
    input  logic [LEN-1:0]   cap_vec,
    output logic [LEN-1:0]   master,
    output logic [LEN-1:0]   slave
);
    // master stages: parallel load or shift toward bit 0 on rising edge
    always_ff @(posedge tck) begin
        if (rst)          master <= '0;
        else if (stb.cap) master <= cap_vec;
        else if (stb.shf) master <= {tdi, master[LEN-1:1]};
    end

    // slave stages: copy on falling edge
    always_ff @(negedge tck) begin
        if (rst)          slave <= '0;
        else if (stb.upd) slave <= master;
    end
endmodule

// File: rtl/bscan_cellmap.sv
module bscan_cellmap
    import bscan_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_TRI = 3,
    parameter int N_BD  = 2,
    parameter int LEN   = 12
) (
    input  logic [N_IN-1:0]  in_pin,
    input  logic [N_TRI-1:0] core_tri_do,
    input  logic             core_tri_oe,
    input  logic [N_BD-1:0]  pin_bd_di,
    input  logic [N_BD-1:0]  core_bd_oe,
    input  logic [LEN-1:0]   slave,
    output logic [LEN-1:0]   cap_vec,
    output logic [N_IN-1:0]  s_in,
    output logic [N_TRI-1:0] s_tri_do,
    output logic             s_tri_ctl,
    output logic [N_BD-1:0]  s_bd_do,
    output logic [N_BD-1:0]  s_bd_ctl
);
    localparam int TC = tri_ctl_pos(LEN, N_BD, N_TRI);

    for (genvar k = 0; k < N_BD; k++) begin : g_bd
        localparam int PD = bd_data_pos(LEN, k);
        localparam int PC = bd_ctl_pos(LEN, k);
        assign cap_vec[PD] = pin_bd_di[k];
        assign cap_vec[PC] = core_bd_oe[k];
        assign s_bd_do[k]  = slave[PD];
        assign s_bd_ctl[k] = slave[PC];
    end

    for (genvar j = 0; j < N_TRI; j++) begin : g_tri
        localparam int PT = tri_data_pos(LEN, N_BD, j);
        assign cap_vec[PT]  = core_tri_do[j];
        assign s_tri_do[j]  = slave[PT];
    end

    // control cell holds 1 for high impedance, so the enable is inverted
    assign cap_vec[TC] = ~core_tri_oe;
    assign s_tri_ctl   = slave[TC];

    for (genvar m = 0; m < N_IN; m++) begin : g_in
        localparam int PI = in_pos(N_IN, m);
        assign cap_vec[PI] = in_pin[m];
        assign s_in[m]     = slave[PI];
    end
endmodule

// File: rtl/bscan_pinmux.sv
module bscan_pinmux #(
    parameter int N_IN  = 4,
    parameter int N_TRI = 3,
    parameter int N_BD  = 2
) (
    input  logic             ext,
    input  logic [N_IN-1:0]  in_pin,
    input  logic [N_TRI-1:0] core_tri_do,
    input  logic             core_tri_oe,
    input  logic [N_BD-1:0]  core_bd_do,
    input  logic [N_BD-1:0]  core_bd_oe,
    input  logic [N_BD-1:0]  pin_bd_di,
    input  logic [N_IN-1:0]  s_in,
    input  logic [N_TRI-1:0] s_tri_do,
    input  logic             s_tri_ctl,
    input  logic [N_BD-1:0]  s_bd_do,
    input  logic [N_BD-1:0]  s_bd_ctl,
    output logic [N_IN-1:0]  core_in,
    output logic [N_TRI-1:0] pin_tri_do,
    output logic             pin_tri_oe,
    output logic [N_BD-1:0]  pin_bd_do,
    output logic [N_BD-1:0]  pin_bd_oe,
    output logic [N_BD-1:0]  core_bd_di
);
    always_comb begin
        if (ext) begin
            core_in    = s_in;
            pin_tri_do = s_tri_do;
            pin_tri_oe = ~s_tri_ctl;
            pin_bd_do  = s_bd_do;
            pin_bd_oe  = s_bd_ctl;
            core_bd_di = s_bd_do;
        end else begin
            core_in    = in_pin;
            pin_tri_do = core_tri_do;
            pin_tri_oe = core_tri_oe;
            pin_bd_do  = core_bd_do;
            pin_bd_oe  = core_bd_oe;
            core_bd_di = pin_bd_di;
        end
    end
endmodule

// File: rtl/bscan_tdo.sv
module bscan_tdo (
    input  logic tck,
    input  logic rst,
    input  logic shift_any,
    input  logic use_chain,
    input  logic chain_lsb,
    input  logic byp_q,
    output logic tdo,
    output logic tdo_oe
);
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shift_any;
            if (shift_any) tdo <= use_chain ? chain_lsb : byp_q;
        end
    end
endmodule

// File: rtl/bscan_dr_path.sv
module bscan_dr_path
    import bscan_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_TRI = 3,
    parameter int N_BD  = 2
) (
    input  logic             tck,
    input  logic             rst,
    input  logic             tdi,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic [1:0]       instr,
    output logic             tdo,
    output logic             tdo_oe,
    input  logic [N_IN-1:0]  in_pin,
    output logic [N_IN-1:0]  core_in,
    input  logic [N_TRI-1:0] core_tri_do,
    input  logic             core_tri_oe,
    output logic [N_TRI-1:0] pin_tri_do,
    output logic             pin_tri_oe,
    input  logic [N_BD-1:0]  core_bd_do,
    input  logic [N_BD-1:0]  core_bd_oe,
    output logic [N_BD-1:0]  pin_bd_do,
    output logic [N_BD-1:0]  pin_bd_oe,
    input  logic [N_BD-1:0]  pin_bd_di,
    output logic [N_BD-1:0]  core_bd_di
);
    localparam int LEN = chain_len(N_IN, N_TRI, N_BD);

    dr_instr_e  code;
    logic       use_chain;
    logic       ext;
    dr_strobe_t stb_chain;
    dr_strobe_t stb_byp;

    assign code      = dr_instr_e'(instr);
    assign use_chain = picks_boundary(code);
    assign ext       = (code == INS_EXTEST);

    assign stb_chain = '{cap: capture_dr & use_chain,
                         shf: shift_dr   & use_chain,
                         upd: update_dr  & use_chain};
    assign stb_byp   = '{cap: capture_dr & ~use_chain,
                         shf: shift_dr   & ~use_chain,
                         upd: 1'b0};

    logic [LEN-1:0]   cap_vec;
    logic [LEN-1:0]   master;
    logic [LEN-1:0]   slave;
    logic             byp_q;
    logic [N_IN-1:0]  s_in;
    logic [N_TRI-1:0] s_tri_do;
    logic             s_tri_ctl;
    logic [N_BD-1:0]  s_bd_do;
    logic [N_BD-1:0]  s_bd_ctl;

    bscan_bypass u_byp (
        .tck (tck),
        .rst (rst),
        .stb (stb_byp),
        .tdi (tdi),
        .q   (byp_q)
    );

    bscan_chain #(.LEN(LEN)) u_chain (
        .tck     (tck),
        .rst     (rst),
        .stb     (stb_chain),
        .tdi     (tdi),
        .cap_vec (cap_vec),
        .master  (master),
        .slave   (slave)
    );

    bscan_cellmap #(
        .N_IN(N_IN), .N_TRI(N_TRI), .N_BD(N_BD), .LEN(LEN)
    ) u_map (
        .in_pin      (in_pin),
        .core_tri_do (core_tri_do),
        .core_tri_oe (core_tri_oe),
        .pin_bd_di   (pin_bd_di),
        .core_bd_oe  (core_bd_oe),
        .slave       (slave),
        .cap_vec     (cap_vec),
        .s_in        (s_in),
        .s_tri_do    (s_tri_do),
        .s_tri_ctl   (s_tri_ctl),
        .s_bd_do     (s_bd_do),
        .s_bd_ctl    (s_bd_ctl)
    );

    bscan_pinmux #(
        .N_IN(N_IN), .N_TRI(N_TRI), .N_BD(N_BD)
    ) u_mux (
        .ext         (ext),
        .in_pin      (in_pin),
        .core_tri_do (core_tri_do),
        .core_tri_oe (core_tri_oe),
        .core_bd_do  (core_bd_do),
        .core_bd_oe  (core_bd_oe),
        .pin_bd_di   (pin_bd_di),
        .s_in        (s_in),
        .s_tri_do    (s_tri_do),
        .s_tri_ctl   (s_tri_ctl),
        .s_bd_do     (s_bd_do),
        .s_bd_ctl    (s_bd_ctl),
        .core_in     (core_in),
        .pin_tri_do  (pin_tri_do),
        .pin_tri_oe  (pin_tri_oe),
        .pin_bd_do   (pin_bd_do),
        .pin_bd_oe   (pin_bd_oe),
        .core_bd_di  (core_bd_di)
    );

    bscan_tdo u_tdo (
        .tck       (tck),
        .rst       (rst),
        .shift_any (shift_dr),
        .use_chain (use_chain),
        .chain_lsb (master[0]),
        .byp_q     (byp_q),
        .tdo       (tdo),
        .tdo_oe    (tdo_oe)
    );
endmodule

// File: rtl/bscan_dr_path_chk.sv
module bscan_dr_path_chk #(
    parameter int N_IN = 4,
    parameter int N_BD = 2
) (
    input logic            tck,
    input logic            rst,
    input logic            tdi,
    input logic            shift_dr,
    input logic            update_dr,
    input logic [1:0]      instr,
    input logic            tdo,
    input logic            tdo_oe,
    input logic [N_IN-1:0] in_pin,
    input logic [N_IN-1:0] core_in,
    input logic [N_BD-1:0] core_bd_do,
    input logic [N_BD-1:0] pin_bd_do,
    input logic [N_BD-1:0] pin_bd_oe
);
    logic is_ext;
    logic byp_shift;
    assign is_ext    = (instr == 2'd2);
    assign byp_shift = shift_dr && (instr != 2'd1) && (instr != 2'd2);

    // R9
    oe_off_chk: assert property (@(negedge tck) disable iff (rst)
        !shift_dr |=> !tdo_oe);

    // R9
    oe_on_chk: assert property (@(negedge tck) disable iff (rst)
        shift_dr |=> tdo_oe);

    // R2
    transparent_chk: assert property (@(posedge tck) disable iff (rst)
        !is_ext |-> (core_in == in_pin && pin_bd_do == core_bd_do));

    // R3
    byp_delay_chk: assert property (@(negedge tck) disable iff (rst)
        (byp_shift && $past(byp_shift)) |=> (tdo == $past(tdi, 2)));

    // R6
    hold_slave_chk: assert property (@(negedge tck) disable iff (rst)
        (is_ext && !update_dr) |=>
            (!is_ext || ($stable(pin_bd_do) && $stable(pin_bd_oe))));
endmodule

bind bscan_dr_path bscan_dr_path_chk #(.N_IN(N_IN), .N_BD(N_BD)) u_chk (
    .tck        (tck),
    .rst        (rst),
    .tdi        (tdi),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .instr      (instr),
    .tdo        (tdo),
    .tdo_oe     (tdo_oe),
    .in_pin     (in_pin),
    .core_in    (core_in),
    .core_bd_do (core_bd_do),
    .pin_bd_do  (pin_bd_do),
    .pin_bd_oe  (pin_bd_oe)
);

// File: tb/bscan_dr_path_bench.sv
module bscan_dr_path_bench;
    localparam int NI = 4;
    localparam int NT = 3;
    localparam int NB = 2;
    localparam int L  = 2 * NB + NT + 1 + NI;
    localparam int W  = NI + NT + 1 + NB + NB;
    localparam int NV = 6;

    // {in_pin, core_tri_do, core_tri_oe, pin_bd_di, core_bd_oe}
    localparam logic [W-1:0] VEC [NV] = '{
        12'hA5C, 12'h3F1, 12'h000, 12'hFFF, 12'h5A6, 12'hC39
    };

    logic          tck = 1'b0;
    logic          rst = 1'b1;
    logic          tdi = 1'b0;
    logic          capture_dr = 1'b0;
    logic          shift_dr = 1'b0;
    logic          update_dr = 1'b0;
    logic [1:0]    instr = 2'd0;
    logic          tdo, tdo_oe;
    logic [NI-1:0] in_pin = '0;
    logic [NI-1:0] core_in;
    logic [NT-1:0] core_tri_do = '0;
    logic          core_tri_oe = 1'b0;
    logic [NT-1:0] pin_tri_do;
    logic          pin_tri_oe;
    logic [NB-1:0] core_bd_do = '0;
    logic [NB-1:0] core_bd_oe = '0;
    logic [NB-1:0] pin_bd_do, pin_bd_oe;
    logic [NB-1:0] pin_bd_di = '0;
    logic [NB-1:0] core_bd_di;

    int total = 0;
    int bad   = 0;

    always #10 tck = ~tck;

    bscan_dr_path #(.N_IN(NI), .N_TRI(NT), .N_BD(NB)) u_bscan_dr_path (
        .tck(tck), .rst(rst), .tdi(tdi), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .instr(instr),
        .tdo(tdo), .tdo_oe(tdo_oe), .in_pin(in_pin), .core_in(core_in),
        .core_tri_do(core_tri_do), .core_tri_oe(core_tri_oe),
        .pin_tri_do(pin_tri_do), .pin_tri_oe(pin_tri_oe),
        .core_bd_do(core_bd_do), .core_bd_oe(core_bd_oe),
        .pin_bd_do(pin_bd_do), .pin_bd_oe(pin_bd_oe),
        .pin_bd_di(pin_bd_di), .core_bd_di(core_bd_di)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one test clock: inputs applied a quarter period after a rising edge
    task automatic cyc();
        @(negedge tck);
        @(posedge tck);
        #5;
    endtask

    task automatic strobes(input logic c, input logic s, input logic u);
        capture_dr = c; shift_dr = s; update_dr = u;
    endtask

    task automatic shift_vec(input logic [L-1:0] din, output logic [L-1:0] dout);
        for (int i = 0; i < L; i++) begin
            tdi = din[i];
            strobes(1'b0, 1'b1, 1'b0);
            cyc();
            dout[i] = tdo;
        end
        strobes(1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [L-1:0] pack(logic [NB-1:0] bdd, logic [NB-1:0] bdc,
                                          logic [NT-1:0] td, logic tc, logic [NI-1:0] iv);
        logic [L-1:0] v;
        v = '0;
        for (int k = 0; k < NB; k++) begin
            v[L-1-2*k] = bdd[k];
            v[L-2-2*k] = bdc[k];
        end
        for (int j = 0; j < NT; j++) v[L-1-2*NB-j] = td[j];
        v[L-1-2*NB-NT] = tc;
        for (int m = 0; m < NI; m++) v[NI-1-m] = iv[m];
        return v;
    endfunction

    task automatic load_update(input logic [L-1:0] v);
        logic [L-1:0] junk;
        shift_vec(v, junk);
        strobes(1'b0, 1'b0, 1'b1);
        cyc();
        strobes(1'b0, 1'b0, 1'b0);
    endtask

    task automatic bypass_run(input string req, input logic [1:0] code);
        logic [3:0] bits;
        logic [3:0] seen;
        bits = 4'b1101;
        instr = code;
        strobes(1'b1, 1'b0, 1'b0);
        cyc();
        for (int i = 0; i < 4; i++) begin
            tdi = bits[i];
            strobes(1'b0, 1'b1, 1'b0);
            cyc();
            seen[i] = tdo;
        end
        strobes(1'b0, 1'b0, 1'b1);
        cyc();
        strobes(1'b0, 1'b0, 1'b0);
        chk(req, {28'd0, seen}, {28'd0, bits[2:0], 1'b0});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge tck);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [L-1:0] got;
        logic [L-1:0] exp;
        logic [L-1:0] p2;
        repeat (3) @(posedge tck);
        #5;
        rst = 1'b0;
        cyc();

        // R1 reset state seen through external-test pins
        instr = 2'd2;
        cyc();
        chk("R1 tdo", {31'd0, tdo}, 32'd0);
        chk("R1 tdo_oe", {31'd0, tdo_oe}, 32'd0);
        chk("R1 pins", {22'd0, core_in, pin_bd_do, pin_bd_oe, pin_tri_do, pin_tri_oe},
            {22'd0, 4'd0, 2'd0, 2'd0, 3'd0, 1'b1});

        // table walk: sample capture and serial readout
        instr = 2'd1;
        for (int n = 0; n < NV; n++) begin
            {in_pin, core_tri_do, core_tri_oe, pin_bd_di, core_bd_oe} = VEC[n];
            core_bd_do = VEC[n][1:0] ^ 2'b10;
            #1;
            chk("R2 transparent", {16'd0, core_in, pin_tri_do, pin_tri_oe, pin_bd_do, pin_bd_oe, core_bd_di},
                {16'd0, in_pin, core_tri_do, core_tri_oe, core_bd_do, core_bd_oe, pin_bd_di});
            strobes(1'b1, 1'b0, 1'b0);
            cyc();
            exp = pack(pin_bd_di, core_bd_oe, core_tri_do, ~core_tri_oe, in_pin);
            shift_vec('0, got);
            chk("R4 capture order", {20'd0, got}, {20'd0, exp});
        end

        // R5 no inversion, length L; R9 tdo_oe during and after shift
        shift_vec(12'h9C3, got);
        chk("R9 tdo_oe during shift", {31'd0, tdo_oe}, 32'd1);
        shift_vec(12'h000, got);
        chk("R5 pass-through", {20'd0, got}, 32'h9C3);
        cyc();
        chk("R9 tdo_oe idle", {31'd0, tdo_oe}, 32'd0);

        // R6/R7/R8 external test loading
        instr = 2'd2;
        cyc();
        p2 = pack(2'b01, 2'b10, 3'b101, 1'b1, 4'b0110);
        shift_vec(p2, got);
        chk("R6 no update yet", {28'd0, pin_bd_do, pin_tri_oe, pin_tri_do[0]}, {28'd0, 2'b00, 1'b1, 1'b0});
        strobes(1'b0, 1'b0, 1'b1);
        @(negedge tck);
        #2;
        chk("R6 falling edge", {30'd0, pin_bd_do}, 32'b01);
        @(posedge tck);
        #5;
        strobes(1'b0, 1'b0, 1'b0);
        chk("R7 ctl 1 floats", {28'd0, pin_tri_oe, pin_tri_do}, {28'd0, 1'b0, 3'b101});
        chk("R8 bidi", {24'd0, pin_bd_oe, pin_bd_do, core_bd_di}, {24'd0, 2'b10, 2'b01, 2'b01});
        chk("R8 inputs", {28'd0, core_in}, 32'b0110);
        load_update(pack(2'b10, 2'b01, 3'b010, 1'b0, 4'b1001));
        chk("R7 ctl 0 drives", {28'd0, pin_tri_oe, pin_tri_do}, {28'd0, 1'b1, 3'b010});
        chk("R8 reload", {26'd0, pin_bd_oe, pin_bd_do, core_bd_di}, {26'd0, 2'b01, 2'b10, 2'b10});

        // R3 bypass, R10 boundary untouched
        bypass_run("R3 one-bit delay", 2'd0);
        instr = 2'd2;
        #1;
        chk("R10 slaves kept", {22'd0, core_in, pin_bd_do, pin_bd_oe, pin_tri_do, pin_tri_oe},
            {22'd0, 4'b1001, 2'b10, 2'b01, 3'b010, 1'b1});

        // R11 spare code acts as bypass
        bypass_run("R11 spare code", 2'd3);
        instr = 2'd2;
        #1;
        chk("R11 slaves kept", {28'd0, core_in}, 32'b1001);

        // R6 update under sample stays invisible until external test
        instr = 2'd1;
        cyc();
        load_update(pack(2'b11, 2'b11, 3'b111, 1'b0, 4'b1111));
        in_pin = 4'b0100;
        #1;
        chk("R6 sample transparent", {28'd0, core_in}, 32'b0100);
        instr = 2'd2;
        #1;
        chk("R6 sample updated", {22'd0, core_in, pin_bd_do, pin_bd_oe, pin_tri_do, pin_tri_oe},
            {22'd0, 4'b1111, 2'b11, 2'b11, 3'b111, 1'b1});
        cyc();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule